// File: doc/BRIEF.md
# High-Speed Chirp Handshake Sequencer

This block takes a USB device from a detected bus reset into high-speed operation without software pacing. It owns the transceiver control word. That word holds the operating mode, the transceiver select, the termination select, the two data-line pull-downs and the chirp enable. The block steps this word through a fixed series of modes: detached, full-speed attached, device chirp, host-chirp listen and high-speed. Time is measured in millisecond ticks supplied from outside. While listening, the block counts the host's chirp transitions on the two-bit line state input.

If the host's chirps never arrive, a listen timeout returns the device to full-speed attached mode. If the device is reset again and again without an intervening detach, the sequencer drops its pull-up for a fixed number of milliseconds and then re-attaches. A sticky bus-reset flag records each reset seen while attached. A write-one-style clear input or a re-attach clears it. A one-cycle done pulse marks the end of each chirp handshake.

Top module: `hs_chirp_seq`

## Requirements
- R1: The control word packs chirp enable at bit 8, D- pull-down at bit 7, D+ pull-down at bit 6, termination select at bit 5, transceiver select at bits 4:3, operating mode at bits 2:1, with bit 0 always 0. After reset the word is the detached value 0x002 (operating mode 1), and the high-speed flag, done pulse and reset flag are all 0.
- R2: With attach high, a detached block shows the full-speed word 0x028 (operating mode 0, transceiver select 1, termination 1) one cycle later. Attach low in any state gives 0x002 one cycle later and clears the repeated-reset count.
- R3: A bus reset pulse in full-speed or high-speed state, with at most MAX_RESETS (4) handshakes counted, gives the device-chirp word 0x124 (operating mode 2, termination 1, chirp enable 1) one cycle later.
- R4: The device-chirp word holds for CHIRP_MS (3) millisecond ticks, whatever the gaps between them. The listen word 0x024 (operating mode 2, termination 1) appears in the cycle after the last of those ticks.
- R5: In listen mode, each cycle in which line state differs from the previous cycle's value and equals 1 or 2 counts one chirp. The previous value is taken as 3 on entry to listen mode. The cycle after the CHIRP_COUNT-th (5) chirp shows the high-speed word 0x000 with the high-speed flag at 1.
- R6: If LISTEN_MS (10) ticks pass in listen mode without five chirps, the word returns to 0x028 in the cycle after the tenth tick, with the high-speed flag at 0.
- R7: The done pulse is high for exactly one cycle, in the same cycle as the word that ends listen mode (high-speed or full-speed fallback). It is not raised when attach drops during listen.
- R8: A bus reset arriving when more than MAX_RESETS handshakes have been counted gives the detached word 0x002 for DETACH_MS (100) ticks. The full-speed word 0x028 follows in the cycle after the last tick, and the count restarts from zero.
- R9: The reset flag is set by a bus reset while attached. It is cleared by the clear input, by attaching from detached, or by the re-attach after a forced detach. A set and a clear in the same cycle leave it set.
- R10: When the fifth chirp and the tenth listen tick fall in the same cycle, the block enters high-speed mode, not full-speed.
- R11: A bus reset pulse while detached changes neither the word nor the reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| attach_i | input | 1 | Attach request level (pull-up wanted) |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset detected |
| line_state_i | input | 2 | Synchronized line state from the transceiver |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| rst_flag_clr_i | input | 1 | Clear request for the reset flag |
| xcvr_ctrl_o | output | 9 | Registered transceiver control word |
| hs_active_o | output | 1 | High-speed operation active |
| rst_done_o | output | 1 | One-cycle pulse at the end of a chirp handshake |
| rst_flag_o | output | 1 | Sticky bus-reset flag |

## Verification
Two pairs of functions can land in the same cycle. In listen mode, the chirp count can complete in the same cycle that the timeout expires. For the reset flag, a new bus reset can arrive in the same cycle as a clear request. The bench first drives four chirp transitions, then nine ticks while holding the line still. It then applies the fifth transition together with the tenth tick, and expects the high-speed word and a done pulse in the next cycle. For the flag, it raises the clear input in the same cycle as a bus reset and expects the flag to read 1 afterwards.

// File: rtl/hs_chirp_pkg.sv
package hs_chirp_pkg;

  localparam int CW_W = 9;

  typedef enum logic [2:0] {
    ST_DETACHED = 3'd0,
    ST_FS       = 3'd1,
    ST_PCHIRP   = 3'd2,
    ST_LISTEN   = 3'd3,
    ST_HS       = 3'd4,
    ST_FORCED   = 3'd5
  } seq_state_t;

  // Field packing of the transceiver control word
  function automatic logic [CW_W-1:0] pack_ctrl(
    input logic       chirp_en,
    input logic       dm_pd,
    input logic       dp_pd,
    input logic       term_sel,
    input logic [1:0] xcvr_sel,
    input logic [1:0] op_mode
  );
    return {chirp_en, dm_pd, dp_pd, term_sel, xcvr_sel, op_mode, 1'b0};
  endfunction

  function automatic logic [CW_W-1:0] state_ctrl(input seq_state_t s);
    case (s)
      ST_FS:     return pack_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0);
      ST_PCHIRP: return pack_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2);
      ST_LISTEN: return pack_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2);
      ST_HS:     return pack_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0);
      default:   return pack_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1);
    endcase
  endfunction

  // A chirp is a move of line state onto J or K
  function automatic logic is_chirp_edge(input logic [1:0] prev, input logic [1:0] cur);
    return (cur != prev) && ((cur == 2'd1) || (cur == 2'd2));
  endfunction

endpackage

// File: rtl/hs_tick_timer.sv
module hs_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            count_o <= '0;
    else if (clr_i)                        count_o <= '0;
    else if (tick_i && (count_o != '1))    count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/hs_chirp_counter.sv
module hs_chirp_counter
  import hs_chirp_pkg::*;
#(
  parameter int MAX_CNT = 5,
  localparam int CNT_W  = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [1:0]       line_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] count_o
);
  logic [1:0] prev_q;

  assign hit_o = en_i && is_chirp_edge(prev_q, line_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 2'd3;
      count_o <= '0;
    end else if (clr_i) begin
      prev_q  <= 2'd3;
      count_o <= '0;
    end else if (en_i) begin
      prev_q <= line_i;
      if (hit_o && (count_o != CNT_W'(MAX_CNT))) count_o <= count_o + 1'b1;
    end
  end

  // R5
  chirp_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/hs_reset_tracker.sv
module hs_reset_tracker #(
  parameter int MAX_RESETS = 4,
  localparam int CNT_W     = $clog2(MAX_RESETS + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic over_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            cnt_q <= '0;
    else if (clr_i)                                        cnt_q <= '0;
    else if (inc_i && (cnt_q != CNT_W'(MAX_RESETS + 1)))   cnt_q <= cnt_q + 1'b1;
  end

  assign over_o = (cnt_q > CNT_W'(MAX_RESETS));

  // R8
  rst_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_RESETS + 1));
endmodule

// File: rtl/hs_chirp_seq.sv
module hs_chirp_seq
  import hs_chirp_pkg::*;
#(
  parameter int CHIRP_MS    = 3,
  parameter int LISTEN_MS   = 10,
  parameter int DETACH_MS   = 100,
  parameter int CHIRP_COUNT = 5,
  parameter int MAX_RESETS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            attach_i,
  input  logic            bus_rst_i,
  input  logic [1:0]      line_state_i,
  input  logic            ms_tick_i,
  input  logic            rst_flag_clr_i,
  output logic [CW_W-1:0] xcvr_ctrl_o,
  output logic            hs_active_o,
  output logic            rst_done_o,
  output logic            rst_flag_o
);
  localparam int MAX_MS = (DETACH_MS > LISTEN_MS) ?
                          ((DETACH_MS > CHIRP_MS) ? DETACH_MS : CHIRP_MS) :
                          ((LISTEN_MS > CHIRP_MS) ? LISTEN_MS : CHIRP_MS);
  localparam int TMR_W  = $clog2(MAX_MS + 1);
  localparam int CHP_W  = $clog2(CHIRP_COUNT + 1);

  seq_state_t       state_q, state_d;
  logic [TMR_W-1:0] ms_cnt;
  logic [CHP_W-1:0] chirp_cnt;
  logic             chirp_hit, rst_over, rst_inc, rst_clr;
  logic             state_change, in_listen, attached_q;
  logic             chirp_done, listen_expire, pchirp_expire, detach_expire;
  logic             flag_set, flag_clr, done_d;

  assign state_change = (state_d != state_q);
  assign in_listen    = (state_q == ST_LISTEN);
  assign attached_q   = (state_q == ST_FS) || (state_q == ST_HS) ||
                        (state_q == ST_PCHIRP) || (state_q == ST_LISTEN);

  hs_tick_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(state_change),
    .tick_i(ms_tick_i), .count_o(ms_cnt)
  );

  hs_chirp_counter #(.MAX_CNT(CHIRP_COUNT)) u_chirps (
    .clk(clk), .rst_n(rst_n), .clr_i(state_change), .en_i(in_listen),
    .line_i(line_state_i), .hit_o(chirp_hit), .count_o(chirp_cnt)
  );

  hs_reset_tracker #(.MAX_RESETS(MAX_RESETS)) u_resets (
    .clk(clk), .rst_n(rst_n), .clr_i(rst_clr), .inc_i(rst_inc), .over_o(rst_over)
  );

  // Named events
  assign pchirp_expire = ms_tick_i && (ms_cnt == TMR_W'(CHIRP_MS - 1));
  assign listen_expire = ms_tick_i && (ms_cnt == TMR_W'(LISTEN_MS - 1));
  assign detach_expire = ms_tick_i && (ms_cnt == TMR_W'(DETACH_MS - 1));
  assign chirp_done    = chirp_hit && (chirp_cnt == CHP_W'(CHIRP_COUNT - 1));

  always_comb begin
    state_d = state_q;
    rst_inc = 1'b0;
    done_d  = 1'b0;
    if (!attach_i) begin
      state_d = ST_DETACHED;
    end else begin
      case (state_q)
        ST_DETACHED: state_d = ST_FS;
        ST_FS, ST_HS: begin
          if (bus_rst_i) begin
            if (rst_over) state_d = ST_FORCED;
            else begin
              state_d = ST_PCHIRP;
              rst_inc = 1'b1;
            end
          end
        end
        ST_PCHIRP: if (pchirp_expire) state_d = ST_LISTEN;
        ST_LISTEN: begin
          if (chirp_done) begin
            state_d = ST_HS;
            done_d  = 1'b1;
          end else if (listen_expire) begin
            state_d = ST_FS;
            done_d  = 1'b1;
          end
        end
        ST_FORCED: if (detach_expire) state_d = ST_FS;
        default:   state_d = ST_DETACHED;
      endcase
    end
  end

  assign rst_clr  = !attach_i || ((state_q == ST_FORCED) && (state_d == ST_FS));
  assign flag_set = bus_rst_i && attach_i && attached_q;
  assign flag_clr = rst_flag_clr_i || ((state_d == ST_FS) &&
                    ((state_q == ST_DETACHED) || (state_q == ST_FORCED)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_DETACHED;
      xcvr_ctrl_o <= state_ctrl(ST_DETACHED);
      hs_active_o <= 1'b0;
      rst_done_o  <= 1'b0;
      rst_flag_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      xcvr_ctrl_o <= state_ctrl(state_d);
      hs_active_o <= (state_d == ST_HS);
      rst_done_o  <= done_d;
      if (flag_set)      rst_flag_o <= 1'b1;
      else if (flag_clr) rst_flag_o <= 1'b0;
    end
  end

  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done_o |=> !rst_done_o);
  // R7
  done_leaves_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done_o |-> ($past(xcvr_ctrl_o) == state_ctrl(ST_LISTEN)) &&
                   (hs_active_o || (xcvr_ctrl_o == state_ctrl(ST_FS))));
  // R2
  detach_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !attach_i |=> (xcvr_ctrl_o == state_ctrl(ST_DETACHED)) && !hs_active_o);
  // R9
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_i && attach_i && attached_q) |=> rst_flag_o);
  // R5
  hs_from_chirp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active_o) |-> $past(chirp_hit));
endmodule

// File: tb/sim_hs_chirp_seq.sv
module sim_hs_chirp_seq;
  logic       clk = 1'b0;
  logic       rst_n, attach, bus_rst, ms_tick, flag_clr;
  logic [1:0] line;
  logic [8:0] ctrl;
  logic       hs_act, done, flag;

  always #2 clk = ~clk;

  hs_chirp_seq u0 (
    .clk(clk), .rst_n(rst_n), .attach_i(attach), .bus_rst_i(bus_rst),
    .line_state_i(line), .ms_tick_i(ms_tick), .rst_flag_clr_i(flag_clr),
    .xcvr_ctrl_o(ctrl), .hs_active_o(hs_act), .rst_done_o(done), .rst_flag_o(flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Expected word: sum of weighted fields per R1
  function automatic logic [8:0] ew(int chirp, int term, int xcvr, int opm);
    return 9'(chirp * 256 + term * 32 + xcvr * 8 + opm * 2);
  endfunction
  function automatic logic [8:0] w_det();    return ew(0, 0, 0, 1); endfunction
  function automatic logic [8:0] w_fs();     return ew(0, 1, 1, 0); endfunction
  function automatic logic [8:0] w_pchirp(); return ew(1, 1, 0, 2); endfunction
  function automatic logic [8:0] w_listen(); return ew(0, 1, 0, 2); endfunction
  function automatic logic [8:0] w_hs();     return ew(0, 0, 0, 0); endfunction
  function automatic bit counts(logic [1:0] p, logic [1:0] c);
    return (c != p) && (c inside {2'd1, 2'd2});
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_bus_reset(string req, logic [8:0] exp);
    bus_rst = 1'b1; cyc(); bus_rst = 1'b0;
    chk(req, "word after bus reset", 32'(ctrl), 32'(exp));
  endtask

  task automatic do_chirp();
    for (int i = 0; i < 3; i++) begin
      int gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        cyc();
        chk("R4", "chirp hold", 32'(ctrl), 32'(w_pchirp()));
      end
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
      chk("R4", "chirp tick", 32'(ctrl), 32'(i < 2 ? w_pchirp() : w_listen()));
    end
  endtask

  task automatic listen_to_hs();
    logic [1:0] prev = 2'd3;
    int hits = 0;
    for (int k = 0; k < 1000 && hits < 5; k++) begin
      logic [1:0] v = 2'($urandom % 4);
      line = v; cyc();
      if (counts(prev, v)) hits++;
      prev = v;
      if (hits == 5) begin
        chk("R5", "hs word", 32'(ctrl), 32'(w_hs()));
        chk("R5", "hs flag", 32'(hs_act), 32'd1);
        chk("R7", "done at hs entry", 32'(done), 32'd1);
      end else begin
        chk("R5", "listen word", 32'(ctrl), 32'(w_listen()));
        chk("R7", "no done in listen", 32'(done), 32'd0);
      end
    end
    line = 2'd0; cyc();
    chk("R7", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic listen_timeout();
    line = 2'd0;
    for (int t = 1; t <= 10; t++) begin
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
      chk("R6", "listen timeout word", 32'(ctrl), 32'(t < 10 ? w_listen() : w_fs()));
    end
    chk("R6", "hs flag low", 32'(hs_act), 32'd0);
    chk("R7", "done on fallback", 32'(done), 32'd1);
    cyc();
    chk("R7", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; attach = 1'b0; bus_rst = 1'b0; ms_tick = 1'b0;
    flag_clr = 1'b0; line = 2'd0;
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    chk("R1", "reset word", 32'(ctrl), 32'(w_det()));
    chk("R1", "reset hs", 32'(hs_act), 32'd0);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset flag", 32'(flag), 32'd0);

    // R11: reset while detached
    bus_rst = 1'b1; cyc(); bus_rst = 1'b0;
    chk("R11", "detached word", 32'(ctrl), 32'(w_det()));
    chk("R11", "detached flag", 32'(flag), 32'd0);

    attach = 1'b1; cyc();
    chk("R2", "attach word", 32'(ctrl), 32'(w_fs()));

    // Handshake 1
    do_bus_reset("R3", w_pchirp());
    chk("R9", "flag set", 32'(flag), 32'd1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R9", "flag cleared", 32'(flag), 32'd0);
    do_chirp();
    listen_to_hs();

    // Handshakes 2..5
    for (int k = 2; k <= 5; k++) begin
      if (k == 2) flag_clr = 1'b1;
      do_bus_reset("R3", w_pchirp());
      flag_clr = 1'b0;
      if (k == 2) chk("R9", "set wins over clear", 32'(flag), 32'd1);
      do_chirp();
      if (k == 3 || ($urandom % 2) == 0) listen_timeout();
      else listen_to_hs();
    end

    // Sixth reset: forced detach
    do_bus_reset("R8", w_det());
    chk("R8", "hs low in forced detach", 32'(hs_act), 32'd0);
    for (int t = 1; t <= 100; t++) begin
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
      chk("R8", "forced detach word", 32'(ctrl), 32'(t < 100 ? w_det() : w_fs()));
    end
    chk("R9", "flag cleared by re-attach", 32'(flag), 32'd0);

    // Count restarted: chirp again; then coincident completion and timeout
    do_bus_reset("R8", w_pchirp());
    do_chirp();
    line = 2'd1; cyc();
    line = 2'd2; cyc();
    line = 2'd1; cyc();
    line = 2'd2; cyc();
    for (int t = 0; t < 9; t++) begin
      ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
      chk("R10", "still listening", 32'(ctrl), 32'(w_listen()));
    end
    line = 2'd1; ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
    chk("R10", "hs wins tie", 32'(ctrl), 32'(w_hs()));
    chk("R10", "hs flag on tie", 32'(hs_act), 32'd1);
    chk("R10", "done on tie", 32'(done), 32'd1);

    // Attach dropped during listen
    line = 2'd0;
    do_bus_reset("R3", w_pchirp());
    do_chirp();
    line = 2'd1; cyc();
    attach = 1'b0; cyc();
    chk("R2", "detach from listen", 32'(ctrl), 32'(w_det()));
    chk("R7", "no done on detach", 32'(done), 32'd0);
    attach = 1'b1; line = 2'd0; cyc();
    chk("R2", "re-attach word", 32'(ctrl), 32'(w_fs()));
    do_bus_reset("R2", w_pchirp());

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule